// File: doc/BRIEF.md
# Banked Configurable Interrupt Controller

This block collects interrupt sources in banks of 32 and drives one request line per bank toward the processor. Every source has two configuration bits: a polarity bit and a trigger-kind bit. Together they select level-high, level-low, rising-edge or falling-edge detection. Edge events are held in a per-source pending latch until software acknowledges them. Software can also raise any source on its own by writing to a set register.

A single 32-bit register port reaches every bank. Each bank occupies six consecutive words, and bank n starts at byte n*0x18. A word offset inside a bank selects one of these registers:
- status (read only)
- enable mask
- set (write one to force)
- clear (write one to acknowledge)
- polarity
- trigger kind

Each request line is the registered OR of the bank's status ANDed with its enable mask. Source number k lives in bank k>>5 at bit k&0x1F.

Top module: `bank_irq_ctrl`

## Requirements
- R1: After reset the enable and pending state are zero in every bank, polarity reads 0xFFFFFFFF, the trigger-kind register reads 0x0000E000 in bank 0 and zero elsewhere, and every request line is low.
- R2: Byte address b*0x18 + off selects bank b. The offsets are 0x0 status, 0x4 enable, 0x8 set, 0xC clear, 0x10 polarity and 0x14 trigger kind. An address at or beyond NUM_BANKS*0x18 reads zero and ignores writes.
- R3: With polarity 1 and trigger kind 0 (level-high), the status bit equals the sampled source.
- R4: With polarity 0 and trigger kind 0 (level-low), the status bit equals the inverted sampled source.
- R5: With polarity 1 and trigger kind 1 (rising edge), a 0-to-1 transition of the sampled source sets the status bit. The bit stays set after the source falls.
- R6: With polarity 0 and trigger kind 1 (falling edge), a 1-to-0 transition sets the status bit and a 0-to-1 transition does not.
- R7: Writing ones to the clear register removes those latched pending bits, and writing 0xFFFFFFFF clears every latched bit in the bank. A level source that is still active keeps its status bit set.
- R8: Writing ones to the set register makes those bits pending. An edge event that arrives in the same cycle as a clear of its bit is kept pending.
- R9: A request line is high one cycle after its bank has a bit that is set in both status and enable. A source whose enable bit is zero never raises the line.
- R10: Reads of the set and clear registers return zero. Reads of status return the pending state whatever the enable mask holds.
- R11: Changing a polarity bit while its source is steady creates no edge event.
- R12: Read data appears one cycle after the address. A level change on a source reaches the request line two cycles after it reaches the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| src_i | input | NUM_BANKS*DATA_W | Interrupt sources, bank b in bits [b*32 +: 32] |
| irq_o | output | NUM_BANKS | Registered per-bank request line |

## Verification
A read returns data one cycle after the address is driven. A level source reaches the status word one cycle after it changes and the request line after two. An edge event is latched two cycles after the input transition, and a clear or set write acts at the clock edge that samples it. Every stimulus in the bench records the cycle in which its result falls due. The scoreboard compares the outputs only at that cycle, on the falling clock edge. Polarity flips, and a clear aimed at the exact cycle an edge is latched, are timed against this same cycle count.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int REGS_PER_BANK = 6;
  localparam int BANK_STRIDE   = REGS_PER_BANK * 4;

  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_ENABLE = 3'd1,
    REG_SET    = 3'd2,
    REG_CLEAR  = 3'd3,
    REG_POL    = 3'd4,
    REG_KIND   = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/bic_addr_decode.sv
module bic_addr_decode
  import bic_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  parameter int BANK_W    = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [BANK_W-1:0] bank_o,
  output reg_sel_e          sel_o
);
  logic [31:0] word_idx;
  logic [31:0] bank_num;
  logic [31:0] slot_num;

  always_comb begin
    word_idx = 32'(addr_i) >> 2;
    bank_num = word_idx / 32'(REGS_PER_BANK);
    slot_num = word_idx % 32'(REGS_PER_BANK);
    hit_o    = (addr_i[1:0] == 2'b00) && (bank_num < 32'(NUM_BANKS));
    bank_o   = BANK_W'(bank_num);
    sel_o    = reg_sel_e'(slot_num[2:0]);
  end
endmodule

// File: rtl/bic_bank_cfg.sv
module bic_bank_cfg
  import bic_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] POL_RST  = 32'hFFFF_FFFF,
  parameter logic [31:0] KIND_RST = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] enable_q,
  output logic [DATA_W-1:0] pol_q,
  output logic [DATA_W-1:0] kind_q,
  output logic [DATA_W-1:0] set_mask,
  output logic [DATA_W-1:0] clr_mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      pol_q    <= DATA_W'(POL_RST);
      kind_q   <= DATA_W'(KIND_RST);
    end else if (wr_hit) begin
      case (sel)
        REG_ENABLE: enable_q <= wdata;
        REG_POL:    pol_q    <= wdata;
        REG_KIND:   kind_q   <= wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    set_mask = (wr_hit && sel == REG_SET)   ? wdata : '0;
    clr_mask = (wr_hit && sel == REG_CLEAR) ? wdata : '0;
  end
endmodule

// File: rtl/bic_trigger.sv
module bic_trigger #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] pol,
  input  logic [DATA_W-1:0] kind,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] latch_q,
  output logic [DATA_W-1:0] evt
);
  logic [DATA_W-1:0] smp_q;
  logic [DATA_W-1:0] smp_prev_q;
  logic [DATA_W-1:0] active;
  logic [DATA_W-1:0] rise;
  logic [DATA_W-1:0] fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q      <= '0;
      smp_prev_q <= '0;
    end else begin
      smp_q      <= src;
      smp_prev_q <= smp_q;
    end
  end

  // edges come from raw samples, so a polarity write alone cannot make one
  always_comb begin
    active = ~(smp_q ^ pol);
    rise   = smp_q & ~smp_prev_q;
    fall   = ~smp_q & smp_prev_q;
    evt    = kind & ((pol & rise) | (~pol & fall));
    status = (~kind & active) | latch_q;
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= (latch_q & ~clr_mask) | evt | set_mask;
  end
endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import bic_pkg::*;
#(
  parameter int          NUM_BANKS      = 2,
  parameter int          ADDR_W         = 8,
  parameter int          DATA_W         = 32,
  parameter logic [31:0] BANK0_KIND_RST = 32'h0000_E000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rd_data,
  input  logic [NUM_BANKS*DATA_W-1:0] src_i,
  output logic [NUM_BANKS-1:0]        irq_o
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              hit;
  logic [BANK_W-1:0] bank_idx;
  reg_sel_e          sel;

  logic [DATA_W-1:0] status_a [NUM_BANKS];
  logic [DATA_W-1:0] enable_a [NUM_BANKS];
  logic [DATA_W-1:0] pol_a    [NUM_BANKS];
  logic [DATA_W-1:0] kind_a   [NUM_BANKS];

  logic [NUM_BANKS*DATA_W-1:0] status_flat;
  logic [NUM_BANKS*DATA_W-1:0] enable_flat;
  logic [NUM_BANKS*DATA_W-1:0] latch_flat;
  logic [NUM_BANKS*DATA_W-1:0] evt_flat;
  logic [NUM_BANKS-1:0]        irq_next;

  bic_addr_decode #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u_dec (
    .addr_i(addr), .hit_o(hit), .bank_o(bank_idx), .sel_o(sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              wr_hit;
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] clr_mask;
    logic [DATA_W-1:0] latch_q;
    logic [DATA_W-1:0] evt;

    assign wr_hit = wr_en && hit && (bank_idx == BANK_W'(b));

    bic_bank_cfg #(
      .DATA_W(DATA_W),
      .POL_RST(32'hFFFF_FFFF),
      .KIND_RST((b == 0) ? BANK0_KIND_RST : 32'h0000_0000)
    ) u_cfg (
      .clk(clk), .rst(rst), .wr_hit(wr_hit), .sel(sel), .wdata(wdata),
      .enable_q(enable_a[b]), .pol_q(pol_a[b]), .kind_q(kind_a[b]),
      .set_mask(set_mask), .clr_mask(clr_mask)
    );

    bic_trigger #(.DATA_W(DATA_W)) u_trig (
      .clk(clk), .rst(rst),
      .src(src_i[b*DATA_W +: DATA_W]),
      .pol(pol_a[b]), .kind(kind_a[b]),
      .set_mask(set_mask), .clr_mask(clr_mask),
      .status(status_a[b]), .latch_q(latch_q), .evt(evt)
    );

    assign status_flat[b*DATA_W +: DATA_W] = status_a[b];
    assign enable_flat[b*DATA_W +: DATA_W] = enable_a[b];
    assign latch_flat[b*DATA_W +: DATA_W]  = latch_q;
    assign evt_flat[b*DATA_W +: DATA_W]    = evt;
    assign irq_next[b] = |(status_a[b] & enable_a[b]);
  end

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (hit) begin
      case (sel)
        REG_STATUS: rd_next = status_a[bank_idx];
        REG_ENABLE: rd_next = enable_a[bank_idx];
        REG_POL:    rd_next = pol_a[bank_idx];
        REG_KIND:   rd_next = kind_a[bank_idx];
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_o   <= '0;
    end else begin
      rd_data <= rd_next;
      irq_o   <= irq_next;
    end
  end
endmodule

// File: rtl/bank_irq_ctrl_chk.sv
module bank_irq_ctrl_chk
  import bic_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [DATA_W-1:0]           wdata,
  input logic [DATA_W-1:0]           rd_data,
  input logic [NUM_BANKS-1:0]        irq_o,
  input logic [NUM_BANKS*DATA_W-1:0] status_flat,
  input logic [NUM_BANKS*DATA_W-1:0] enable_flat,
  input logic [NUM_BANKS*DATA_W-1:0] latch_flat,
  input logic [NUM_BANKS*DATA_W-1:0] evt_flat
);
  logic zero_reg;
  always_comb begin
    zero_reg = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(b*BANK_STRIDE + 8) || addr == ADDR_W'(b*BANK_STRIDE + 12))
        zero_reg = 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (irq_o == '0 && rd_data == '0)); // R1

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(zero_reg) |-> rd_data == '0); // R10

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(b*BANK_STRIDE + 8);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(b*BANK_STRIDE + 12);

    AST_LINE_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (rst)
      irq_o[b] == $past(|(status_flat[b*DATA_W +: DATA_W] & enable_flat[b*DATA_W +: DATA_W]))); // R9

    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && addr == SET_A) |->
        (latch_flat[b*DATA_W +: DATA_W] & $past(wdata)) == $past(wdata)); // R8

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && addr == CLR_A) |->
        (latch_flat[b*DATA_W +: DATA_W] & $past(wdata) & ~$past(evt_flat[b*DATA_W +: DATA_W])) == '0); // R7
  end
endmodule

bind bank_irq_ctrl bank_irq_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rd_data(rd_data), .irq_o(irq_o), .status_flat(status_flat),
  .enable_flat(enable_flat), .latch_flat(latch_flat), .evt_flat(evt_flat)
);

// File: tb/bank_irq_ctrl_test.sv
module bank_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int AW = 8;
  localparam int DW = 32;

  localparam int O_STAT = 0;
  localparam int O_EN   = 4;
  localparam int O_SET  = 8;
  localparam int O_CLR  = 12;
  localparam int O_POL  = 16;
  localparam int O_KIND = 20;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rd_data;
  logic [NB*DW-1:0] src = '0;
  logic [NB-1:0]  irq;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    int          due;
    bit          is_irq;
    int          bank;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  bank_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .src_i(src), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each expected item in its due cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.is_irq ? 32'(irq[it.bank]) : rd_data;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [AW-1:0] ra(int b, int off);
    return AW'(b*24 + off);
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_read(logic [AW-1:0] a, logic [31:0] e, string tag);
    item_t it;
    addr = a;
    it.due = cyc + 1; it.is_irq = 1'b0; it.bank = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic expect_irq(int b, logic v, int delay, string tag);
    item_t it;
    it.due = cyc + delay; it.is_irq = 1'b1; it.bank = b; it.exp = 32'(v); it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;

    // R1 reset state
    expect_irq(0, 1'b0, 1, "R1 irq0 after reset");
    expect_irq(1, 1'b0, 1, "R1 irq1 after reset");
    expect_read(ra(0, O_EN),   32'h0,          "R1 enable b0");
    expect_read(ra(0, O_POL),  32'hFFFF_FFFF,  "R1 polarity b0");
    expect_read(ra(0, O_KIND), 32'h0000_E000,  "R1 kind b0");
    expect_read(ra(1, O_KIND), 32'h0,          "R1 kind b1");
    expect_read(ra(1, O_POL),  32'hFFFF_FFFF,  "R1 polarity b1");
    expect_read(ra(1, O_STAT), 32'h0,          "R1 status b1");
    expect_read(AW'(NB*24),    32'h0,          "R2 out of range read");

    // R3 level-high, masked by enable
    src[32+3] = 1'b1;
    idle(2);
    expect_read(ra(1, O_STAT), 32'h8, "R3 level-high status");
    expect_irq(1, 1'b0, 1, "R9 masked source keeps line low");
    expect_read(ra(1, O_STAT), 32'h8, "R10 status readable while disabled");
    bus_write(ra(1, O_EN), 32'h8);
    expect_read(ra(0, O_EN), 32'h0, "R2 bank0 enable untouched");
    expect_read(ra(1, O_EN), 32'h8, "R2 bank1 enable written");
    expect_irq(1, 1'b1, 1, "R9 enabled source raises line");
    idle(1);

    // R12 level latency to line
    src[32+3] = 1'b0;
    expect_irq(1, 1'b1, 1, "R12 line still high one cycle after drop");
    expect_irq(1, 1'b0, 2, "R12 line low two cycles after drop");
    idle(3);

    // R4 level-low
    bus_write(ra(1, O_POL), 32'hFFFF_FFEF);
    idle(2);
    expect_read(ra(1, O_STAT), 32'h10, "R4 level-low active on low input");
    src[32+4] = 1'b1;
    idle(2);
    expect_read(ra(1, O_STAT), 32'h0, "R4 level-low inactive on high input");

    // R5 rising edge on bank0 bit13
    src[13] = 1'b1;
    idle(1);
    src[13] = 1'b0;
    idle(3);
    expect_read(ra(0, O_STAT), 32'h2000, "R5 rising edge held");
    bus_write(ra(0, O_EN), 32'h2000);
    idle(1);
    expect_irq(0, 1'b1, 1, "R9 edge pending raises line");
    idle(1);
    bus_write(ra(0, O_CLR), 32'h2000);
    expect_irq(0, 1'b0, 1, "R7 clear drops line");
    expect_read(ra(0, O_STAT), 32'h0, "R7 clear removes edge pending");
    expect_read(ra(0, O_CLR), 32'h0, "R10 clear reads zero");
    expect_read(ra(0, O_SET), 32'h0, "R10 set reads zero");

    // R6 falling edge on bank1 bit5
    bus_write(ra(1, O_KIND), 32'h20);
    bus_write(ra(1, O_POL), 32'hFFFF_FFCF);
    idle(2);
    src[32+5] = 1'b1;
    idle(3);
    expect_read(ra(1, O_STAT), 32'h0, "R6 rising transition ignored");
    src[32+5] = 1'b0;
    idle(3);
    expect_read(ra(1, O_STAT), 32'h20, "R6 falling transition latched");
    bus_write(ra(1, O_CLR), 32'h20);
    expect_read(ra(1, O_STAT), 32'h0, "R7 falling pending cleared");

    // R11 polarity flips with steady input
    bus_write(ra(1, O_POL), 32'hFFFF_FFEF);
    idle(3);
    expect_read(ra(1, O_STAT), 32'h0, "R11 no event on polarity set");
    bus_write(ra(1, O_POL), 32'hFFFF_FFCF);
    idle(3);
    expect_read(ra(1, O_STAT), 32'h0, "R11 no event on polarity clear");

    // R8 software set, then edge event colliding with clear
    bus_write(ra(1, O_SET), 32'h100);
    expect_read(ra(1, O_STAT), 32'h100, "R8 set forces pending");
    bus_write(ra(1, O_CLR), 32'h100);
    expect_read(ra(1, O_STAT), 32'h0, "R7 clear of set bit");
    bus_write(ra(0, O_SET), 32'h4000);
    src[14] = 1'b1;
    @(negedge clk);
    bus_write(ra(0, O_CLR), 32'h4000);
    idle(1);
    expect_read(ra(0, O_STAT), 32'h4000, "R8 edge event survives same-cycle clear");
    src[14] = 1'b0;
    idle(2);
    bus_write(ra(0, O_CLR), 32'h4000);
    expect_read(ra(0, O_STAT), 32'h0, "R7 later clear removes it");

    // R7 clear-all and still-active level source
    bus_write(ra(0, O_SET), 32'h0000_F00F);
    expect_read(ra(0, O_STAT), 32'h0000_F00F, "R8 multi-bit set");
    bus_write(ra(0, O_CLR), 32'hFFFF_FFFF);
    expect_read(ra(0, O_STAT), 32'h0, "R7 clear all");
    src[0] = 1'b1;
    idle(2);
    bus_write(ra(0, O_CLR), 32'h1);
    expect_read(ra(0, O_STAT), 32'h1, "R7 active level survives clear");
    src[0] = 1'b0;
    idle(2);
    expect_read(ra(0, O_STAT), 32'h0, "R3 level source released");

    idle(4);
    if (!finished) begin
      finished = 1'b1;
      report();
      $finish;
    end
  end
endmodule